// File: doc/BRIEF.md
# Integer ALU with Comparison Flags

This block is the purely combinational integer execution unit of a small load/store core. It receives two 32-bit operands and a 4-bit operation selector. It returns a 32-bit result word in the same cycle. Three comparison flags sit beside the result: operands equal, operand A below operand B as signed numbers, and operand A below operand B as unsigned numbers. The flags are always produced, whatever operation is selected. Branch logic can therefore use them while the result word carries an unrelated operation.

The supported operations are:
- add and subtract, both wrapping modulo 2^32;
- bitwise AND, OR, XOR and NOR;
- a pass of operand B;
- three shifts, with the amount taken from the low bits of operand B;
- an equality compare, whose result word is zero.

The selector map is sparse. Every unused selector code produces a zero result.

Top module: `int_alu`

## Requirements
- R1: Selector 0 gives A + B modulo 2^32.
- R2: Selector 1 gives A - B modulo 2^32, e.g. 0x00132050 - 0xd6620040 = 0x29b12010.
- R3: Selector 2 shifts A left and selector 9 shifts A right, both filling with zeros.
- R4: Selector 10 shifts A right and fills the vacated bits with A's bit 31, e.g. 0x80808080 by 31 gives 0xffffffff.
- R5: Selectors 3, 4, 7 and 8 give bitwise AND, OR, XOR and NOR of A and B; NOR of two zero operands is 0xffffffff.
- R6: Selector 5 gives operand B unchanged.
- R7: Selector 14 gives a result of 0; flag_eq is 1 exactly when A equals B.
- R8: flag_lt is 1 when A < B as two's-complement numbers, and flag_ltu is 1 when A < B as unsigned numbers. Both flags and flag_eq are valid for every selector value.
- R9: Selectors 6, 11, 12, 13 and 15 give a result of 0.
- R10: Every shift uses only bits 4:0 of B as its amount, so an amount of 0xffffff01 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand, and the value that is shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 4 | Operation selector |
| result | output | 32 | Result word |
| flag_eq | output | 1 | A equals B |
| flag_lt | output | 1 | A below B, signed |
| flag_ltu | output | 1 | A below B, unsigned |

## Verification
Directed vectors cover the corners:
- sign-crossing subtraction, which separates modulo wrap from saturation;
- shifts by 31 on a negative word, which separate sign fill from zero fill;
- shift amounts with high garbage bits, which show whether bits above 4 are masked;
- operand pairs with -1 and 1, which separate the signed flag from the unsigned one.

Each of the sixteen selector codes, including the unused ones, is then swept with pseudo-random operands. This shows that the flags stay valid under every selector and that unused codes never leak a partial result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SHL  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_PASS = 4'd5,
    OP_XOR  = 4'd7,
    OP_NOR  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SAR  = 4'd10,
    OP_CMPE = 4'd14
  } op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {DATA_W{sub}};
    sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  input  logic              to_left,
  input  logic              arith,
  output logic [DATA_W-1:0] shifted
);
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] src;
  logic              fill;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      src[i] = to_left ? val[DATA_W-1-i] : val[i];
    end
    fill = arith & ~to_left & val[DATA_W-1];
  end

  assign stage[0] = src;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
                               : stage[s];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shifted[i] = to_left ? stage[SH_W][DATA_W-1-i] : stage[SH_W][i];
    end
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              eq,
  output logic              lt,
  output logic              ltu
);
  logic [DATA_W:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    eq   = ~|diff[DATA_W-1:0];
    ltu  = diff[DATA_W];
    lt   = (a[DATA_W-1] ^ b[DATA_W-1]) ? a[DATA_W-1] : diff[DATA_W-1];
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SEL_W-1:0]  op_sel,
  output logic [DATA_W-1:0] result,
  output logic              flag_eq,
  output logic              flag_lt,
  output logic              flag_ltu
);
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] shift_w;
  logic              is_sub;
  logic              is_left;
  logic              is_arith;

  always_comb begin
    is_sub   = (op_sel == OP_SUB);
    is_left  = (op_sel == OP_SHL);
    is_arith = (op_sel == OP_SAR);
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (is_sub),
    .sum (sum_w)
  );

  alu_shift #(.DATA_W(DATA_W)) u_shift (
    .val     (opnd_a),
    .amt     (opnd_b[SH_W-1:0]),
    .to_left (is_left),
    .arith   (is_arith),
    .shifted (shift_w)
  );

  alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a   (opnd_a),
    .b   (opnd_b),
    .eq  (flag_eq),
    .lt  (flag_lt),
    .ltu (flag_ltu)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:          result = sum_w;
      OP_SHL, OP_SHR, OP_SAR:  result = shift_w;
      OP_AND:                  result = opnd_a & opnd_b;
      OP_OR:                   result = opnd_a | opnd_b;
      OP_XOR:                  result = opnd_a ^ opnd_b;
      OP_NOR:                  result = ~(opnd_a | opnd_b);
      OP_PASS:                 result = opnd_b;
      default:                 result = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [SEL_W-1:0]  op_sel,
  input logic [DATA_W-1:0] result,
  input logic              flag_eq,
  input logic              flag_lt,
  input logic              flag_ltu
);
  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
      // R8: an equal pair can never also be ordered
      assert_eq_excludes_lt_R8 : assert (!(flag_eq && (flag_lt || flag_ltu)))
        else $error("flags ordered while equal");
      // R8: with matching sign bits the signed and unsigned orders agree
      assert_same_sign_order_R8 : assert ((opnd_a[DATA_W-1] != opnd_b[DATA_W-1]) || (flag_lt == flag_ltu))
        else $error("signed/unsigned order disagree");
      // R1: adder output minus B returns A
      assert_add_inverse_R1 : assert ((op_sel != OP_ADD) || (result - opnd_b == opnd_a))
        else $error("add result inconsistent");
      // R5: NOR output has no bit set where either operand has one
      assert_nor_disjoint_R5 : assert ((op_sel != OP_NOR) || ((result & (opnd_a | opnd_b)) == '0))
        else $error("nor overlaps operands");
      // R7: compare selector never produces a nonzero word
      assert_cmpe_zero_R7 : assert ((op_sel != OP_CMPE) || (result == '0))
        else $error("compare result nonzero");
      // R6: pass selector reproduces B
      assert_pass_b_R6 : assert ((op_sel != OP_PASS) || (result == opnd_b))
        else $error("pass result differs from B");
      // R9: unused selectors produce zero
      assert_unused_zero_R9 : assert (!(op_sel inside {4'd6, 4'd11, 4'd12, 4'd13, 4'd15}) || (result == '0))
        else $error("unused selector leaked data");
    end
  end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  logic        clk;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [3:0]  op_sel;
  logic [31:0] result;
  logic        flag_eq;
  logic        flag_lt;
  logic        flag_ltu;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  int_alu u_dut (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_sel   (op_sel),
    .result   (result),
    .flag_eq  (flag_eq),
    .flag_lt  (flag_lt),
    .flag_ltu (flag_ltu)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                          input logic [3:0] s);
    case (s)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a << b[4:0];
      4'd3:    return a & b;
      4'd4:    return a | b;
      4'd5:    return b;
      4'd7:    return a ^ b;
      4'd8:    return ~(a | b);
      4'd9:    return a >> b[4:0];
      4'd10:   return 32'($signed(a) >>> b[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd9: return "R3";
      4'd10: return "R4";
      4'd3, 4'd4, 4'd7, 4'd8: return "R5";
      4'd5: return "R6";
      4'd14: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  // Apply one vector after a rising edge and compare at the falling edge.
  // exp_r is the directed expectation; the model is compared as well.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s,
                       input logic [31:0] exp_r, input string req);
    logic [31:0] mr;
    logic        me, ml, mu;
    @(posedge clk);
    opnd_a = a; opnd_b = b; op_sel = s;
    @(negedge clk);
    mr = ref_res(a, b, s);
    me = (a == b);
    ml = ($signed(a) < $signed(b));
    mu = (a < b);
    n_vec++;
    if (result !== exp_r || result !== mr) begin
      n_fail++;
      $display("FAIL %s result sel=%0d a=%h b=%h got %h expected %h", req, s, a, b, result, mr);
    end else if (flag_eq !== me || flag_lt !== ml || flag_ltu !== mu) begin
      n_fail++;
      $display("FAIL R8 flags sel=%0d a=%h b=%h got eq%b lt%b ltu%b expected eq%b lt%b ltu%b",
               s, a, b, flag_eq, flag_lt, flag_ltu, me, ml, mu);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] ra, rb;
    opnd_a = '0; opnd_b = '0; op_sel = '0;
    // quiet start: all-zero inputs
    apply(32'h0, 32'h0, 4'd0, 32'h0, "R1");
    apply(32'h0ffaa660, 32'h00012304, 4'd0, 32'h0ffbc964, "R1");
    apply(32'hffffffff, 32'h00000001, 4'd0, 32'h0, "R1");
    apply(32'h00132050, 32'hd6620040, 4'd1, 32'h29b12010, "R2");
    apply(32'h50505050, 32'h0000000f, 4'd2, 32'h28280000, "R3");
    apply(32'h50505050, 32'h0000000f, 4'd9, 32'h0000a0a0, "R3");
    apply(32'h80808080, 32'h0000001f, 4'd10, 32'hffffffff, "R4");
    apply(32'h80808080, 32'h00000008, 4'd10, 32'hff808080, "R4");
    apply(32'h80808080, 32'h00000008, 4'd9, 32'h00808080, "R3");
    apply(32'h05050505, 32'hffffff01, 4'd10, 32'h02828282, "R10");
    apply(32'h05050505, 32'hffffff02, 4'd2, 32'h14141414, "R10");
    apply(32'h50505050, 32'h00000020, 4'd9, 32'h50505050, "R10");
    apply(32'h0, 32'h0, 4'd8, 32'hffffffff, "R5");
    apply(32'h0ffaa660, 32'h00012304, 4'd7, 32'h0ffb8564, "R5");
    apply(32'hf0f0ff00, 32'h0ff00ff0, 4'd3, 32'h00f00f00, "R5");
    apply(32'hf0f0ff00, 32'h0ff00ff0, 4'd4, 32'hfff0fff0, "R5");
    apply(32'h12345678, 32'hcafef00d, 4'd5, 32'hcafef00d, "R6");
    apply(32'hdeadbeef, 32'hdeadbeef, 4'd14, 32'h0, "R7");
    apply(32'hdeadbeef, 32'hdeadbeee, 4'd14, 32'h0, "R7");
    apply(32'hffffffff, 32'h00000001, 4'd5, 32'h00000001, "R8");
    apply(32'h00000001, 32'hffffffff, 4'd14, 32'h0, "R8");
    apply(32'h80000000, 32'h7fffffff, 4'd3, 32'h0, "R8");
    apply(32'hffffffff, 32'hffffffff, 4'd6, 32'h0, "R9");
    apply(32'hffffffff, 32'h12345678, 4'd11, 32'h0, "R9");
    apply(32'hffffffff, 32'h12345678, 4'd15, 32'h0, "R9");
    // sweep every selector, including unused ones, with pseudo-random operands
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 120; k++) begin
        ra = $urandom;
        rb = (k % 4 == 0) ? ra : $urandom;
        if (k % 7 == 0) rb = {~ra[31], rb[30:0]};
        apply(ra, rb, 4'(s), ref_res(ra, rb, 4'(s)), req_of(4'(s)));
      end
    end
    finish_run();
  end
endmodule